// File: doc/BRIEF.md
# Audio Line-Output Power Sequencer

This block drives the power-up and power-down of a stereo codec's line output. A host pulses a start or stop command. The block then emits a fixed, ordered list of 8-bit address / 8-bit data register writes toward an external control-bus writer, such as an I2C or SPI master, over a valid/ready handshake. Each write is held until the writer takes it. Between certain writes the block enforces timed waits, so the analog outputs can settle and a PLL can lock. Those waits are derived from a clock-frequency parameter and always rounded up.

On the way up, the sample-rate register is programmed first. The DAC-to-line route, the two volume registers and the line-amp power-save are set next, and the power register is written last. The block then waits for the outputs to rise before releasing power-save and declaring playback. On the way down, power-save is set, the power register is cleared and the route is removed. A final power-save release is held until the outputs have had time to fall. Status outputs report sequencing in progress, valid playback, a completion pulse and a sticky flag for commands that were refused.

Top module: `lineout_pwr_seq`

## Requirements
- R1: A synchronous active-low reset puts the block idle and powered down. Afterwards wr_valid_o, busy_o, playing_o, done_o and cmd_err_o are all 0.
- R2: A start in idle produces exactly these seven writes as (address, data) in hex: (05,27), (02,10), (0A,91), (0D,91), (03,40), (00,6C), (03,00). The power value 0x6C sets bit 2 (DAC), bit 3 (line amp), bit 5 (mixer input amp) and bit 6.
- R3: wr_valid_o stays high with wr_addr_o and wr_data_o unchanged until wr_ready_i is seen high at a clock edge. Each write is taken exactly once. A write without a timed gate raises wr_valid_o in the cycle after the previous acceptance.
- R4: Let `a` be the acceptance edge of the power-up write to address 0x00. The following (03,00) write raises wr_valid_o at edge a+SETTLE_CYC+1, where SETTLE_CYC = ceil(CLK_HZ*SETTLE_MS / (1000*TEST_DIV)).
- R5: Let `a0` be the acceptance edge of the sample-rate write and `b` the acceptance edge of the write before the power write. The power write raises wr_valid_o at edge max(b+1, a0+LOCK_CYC+1), where LOCK_CYC = ceil(CLK_HZ*LOCK_US / (10^6*TEST_DIV)).
- R6: A stop in playback produces exactly these four writes in order: (03,40), (00,40), (02,00), (03,00).
- R7: Let `a` be the acceptance edge of the power-down write (00,40) and `b` the acceptance edge of (02,00). The final (03,00) raises wr_valid_o at edge max(b+1, a+SETTLE_CYC+1). The route removal is not held back by this wait.
- R8: playing_o rises in the cycle after the last power-up write is accepted, provided a DAC-invalid window has elapsed. That window is ceil(DAC_SAMPLES*CLK_HZ / (FS_HZ*TEST_DIV)) cycles, counted from the power-up write's acceptance. playing_o falls in the cycle after a stop is accepted.
- R9: busy_o is high from the cycle after an accepted command until the cycle after the sequence's last write is accepted. It is low in idle and in playback, and never high together with playing_o.
- R10: done_o is high for exactly one cycle, the cycle after the last write of either sequence is accepted.
- R11: A start is accepted only in idle, and a stop only in playback. Any other command produces no write and no state change. It sets cmd_err_o, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Power-up command pulse |
| stop_i | input | 1 | Power-down command pulse |
| wr_valid_o | output | 1 | Register write offered to the bus writer |
| wr_ready_i | input | 1 | Bus writer takes the offered write |
| wr_addr_o | output | 8 | Codec register address |
| wr_data_o | output | 8 | Codec register data |
| busy_o | output | 1 | A sequence is in progress |
| playing_o | output | 1 | Line output in valid playback |
| done_o | output | 1 | One-cycle sequence-complete pulse |
| cmd_err_o | output | 1 | Sticky refused-command flag |

## Verification
During power-down, the handshake of the route-removal write and the expiry of the fall-time wait can land on the same clock edge. Whichever happens later must decide when the last write is offered. The bench provokes this by stalling wr_ready_i on the route-removal write by a computed latency, chosen so that its acceptance lands one cycle before, on, or one cycle after the wait's expiry. In each case it compares the rise edge of the final write with max(acceptance+1, armed edge+SETTLE_CYC+1). Refused commands are also injected while a sequence is running and while in playback, and the bench confirms that the write list and status are left unchanged.

// File: rtl/lo_seq_pkg.sv
// Shared types and constant helpers for the line-output power sequencer.
// Assumes 8-bit codec register addresses and data.
package lo_seq_pkg;

    localparam int REG_AW   = 8;
    localparam int REG_DW   = 8;
    localparam int IDX_W    = 4;
    localparam logic [IDX_W-1:0] UP_FIRST = 4'd0;
    localparam logic [IDX_W-1:0] UP_LAST  = 4'd6;
    localparam logic [IDX_W-1:0] DN_FIRST = 4'd7;
    localparam logic [IDX_W-1:0] DN_LAST  = 4'd10;

    // What a step starts when its write is accepted
    typedef enum logic [1:0] {
        ARM_NONE  = 2'd0,
        ARM_LOCK  = 2'd1,
        ARM_PWRUP = 2'd2,
        ARM_PWRDN = 2'd3
    } arm_e;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
        logic              gate;   // wait for the delay timer before offering
        arm_e              arm;
    } step_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_PLAY = 2'd2,
        ST_DOWN = 2'd3
    } seq_st_e;

    // Integer division that never shortens a delay
    function automatic longint unsigned ceil_div(input longint unsigned num,
                                                 input longint unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Counter width able to hold val (at least one bit)
    function automatic int cnt_width(input longint unsigned val);
        int w;
        w = $clog2(val + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/lo_seq_rom.sv
// Step table for the line-output power sequencer.
// Steps 0..6 bring the output up and 7..10 take it down. The order is behaviour:
// the rate register comes before any power bit, and power-save brackets power changes.
module lo_seq_rom
    import lo_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output step_t            step_o
);

    // Decode the step index into address, data, gate and arm action
    always_comb begin
        step_o = '{addr: 8'h00, data: 8'h00, gate: 1'b0, arm: ARM_NONE};
        case (idx_i)
            4'd0:  step_o = '{addr: 8'h05, data: 8'h27, gate: 1'b0, arm: ARM_LOCK};
            4'd1:  step_o = '{addr: 8'h02, data: 8'h10, gate: 1'b0, arm: ARM_NONE};
            4'd2:  step_o = '{addr: 8'h0A, data: 8'h91, gate: 1'b0, arm: ARM_NONE};
            4'd3:  step_o = '{addr: 8'h0D, data: 8'h91, gate: 1'b0, arm: ARM_NONE};
            4'd4:  step_o = '{addr: 8'h03, data: 8'h40, gate: 1'b0, arm: ARM_NONE};
            4'd5:  step_o = '{addr: 8'h00, data: 8'h6C, gate: 1'b1, arm: ARM_PWRUP};
            4'd6:  step_o = '{addr: 8'h03, data: 8'h00, gate: 1'b1, arm: ARM_NONE};
            4'd7:  step_o = '{addr: 8'h03, data: 8'h40, gate: 1'b0, arm: ARM_NONE};
            4'd8:  step_o = '{addr: 8'h00, data: 8'h40, gate: 1'b0, arm: ARM_PWRDN};
            4'd9:  step_o = '{addr: 8'h02, data: 8'h00, gate: 1'b0, arm: ARM_NONE};
            4'd10: step_o = '{addr: 8'h03, data: 8'h00, gate: 1'b1, arm: ARM_NONE};
            default: ;
        endcase
    end

endmodule

// File: rtl/lo_delay_timer.sv
// Loadable down-counter. expired_o is high whenever the count is zero.
// Assumes a load value of zero means "no wait". It resets to expired.
module lo_delay_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4
    timer_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/lo_seq_ctrl.sv
// Sequencer control: command acceptance, step walking, write handshake and status.
// Assumes the step table and timers are outside. A gated step waits for
// delay_done_i. The DAC-invalid window qualifies playing_o.
module lo_seq_ctrl
    import lo_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  step_t             step_i,
    input  logic              delay_done_i,
    input  logic              dac_ok_i,
    input  logic              wr_ready_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              wr_valid_o,
    output logic [REG_AW-1:0] wr_addr_o,
    output logic [REG_DW-1:0] wr_data_o,
    output logic              delay_load_o,
    output logic              delay_is_lock_o,
    output logic              dac_load_o,
    output logic              busy_o,
    output logic              playing_o,
    output logic              done_o,
    output logic              cmd_err_o
);

    seq_st_e           state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              valid_q;
    logic [REG_AW-1:0] addr_q;
    logic [REG_DW-1:0] data_q;
    logic              done_q;
    logic              err_q;
    logic              in_seq;
    logic              issue;
    logic              accept;
    logic              last_step;
    logic              bad_cmd;

    // Decode handshake events and refused commands
    always_comb begin
        in_seq    = (state_q == ST_UP) || (state_q == ST_DOWN);
        issue     = in_seq && !valid_q && (!step_i.gate || delay_done_i);
        accept    = valid_q && wr_ready_i;
        last_step = (idx_q == UP_LAST) || (idx_q == DN_LAST);
        bad_cmd   = (start_i && state_q != ST_IDLE) || (stop_i && state_q != ST_PLAY);
    end

    // Sequence state, step index, held write and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= UP_FIRST;
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (bad_cmd) begin
                err_q <= 1'b1;
            end
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_UP;
                        idx_q   <= UP_FIRST;
                    end
                end
                ST_PLAY: begin
                    if (stop_i) begin
                        state_q <= ST_DOWN;
                        idx_q   <= DN_FIRST;
                    end
                end
                default: begin
                    if (issue) begin
                        valid_q <= 1'b1;
                        addr_q  <= step_i.addr;
                        data_q  <= step_i.data;
                    end else if (accept) begin
                        valid_q <= 1'b0;
                        if (last_step) begin
                            done_q  <= 1'b1;
                            state_q <= (state_q == ST_UP) ? ST_PLAY : ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Timer arming on acceptance of the arming step
    always_comb begin
        delay_load_o    = accept && (step_i.arm != ARM_NONE);
        delay_is_lock_o = (step_i.arm == ARM_LOCK);
        dac_load_o      = accept && (step_i.arm == ARM_PWRUP);
    end

    assign idx_o      = idx_q;
    assign wr_valid_o = valid_q;
    assign wr_addr_o  = addr_q;
    assign wr_data_o  = data_q;
    assign busy_o     = in_seq;
    assign playing_o  = (state_q == ST_PLAY) && dac_ok_i;
    assign done_o     = done_q;
    assign cmd_err_o  = err_q;

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !wr_ready_i) |=> (valid_q && $stable(addr_q) && $stable(data_q)));

    // R4
    gate_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && step_i.gate) |-> delay_done_i);

    // R9
    busy_play_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !playing_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R11
    cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && !accept) |=> (state_q == ST_UP));

endmodule

// File: rtl/lineout_pwr_seq.sv
// Top of the line-output power sequencer.
// Derives wait lengths from CLK_HZ (rounded up, divided by TEST_DIV for short
// simulations), and wires the step table, control and timers together.
// Assumes clocks and any PLL setup are running before start_i.
module lineout_pwr_seq
    import lo_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 64'd50_000_000,
    parameter longint unsigned SETTLE_MS   = 64'd300,
    parameter longint unsigned LOCK_US     = 64'd0,
    parameter longint unsigned FS_HZ       = 64'd44_100,
    parameter longint unsigned DAC_SAMPLES = 64'd67,
    parameter longint unsigned TEST_DIV    = 64'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        stop_i,
    output logic        wr_valid_o,
    input  logic        wr_ready_i,
    output logic [7:0]  wr_addr_o,
    output logic [7:0]  wr_data_o,
    output logic        busy_o,
    output logic        playing_o,
    output logic        done_o,
    output logic        cmd_err_o
);

    localparam longint unsigned SETTLE_CYC =
        ceil_div(CLK_HZ * SETTLE_MS, 64'd1000 * TEST_DIV);
    localparam longint unsigned LOCK_CYC =
        ceil_div(CLK_HZ * LOCK_US, 64'd1_000_000 * TEST_DIV);
    localparam longint unsigned DAC_CYC =
        ceil_div(DAC_SAMPLES * CLK_HZ, FS_HZ * TEST_DIV);
    localparam longint unsigned DLY_MAX = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
    localparam int DLY_W = cnt_width(DLY_MAX);
    localparam int DAC_W = cnt_width(DAC_CYC);
    localparam logic [DLY_W-1:0] SETTLE_LD = SETTLE_CYC[DLY_W-1:0];
    localparam logic [DLY_W-1:0] LOCK_LD   = LOCK_CYC[DLY_W-1:0];
    localparam logic [DAC_W-1:0] DAC_LD    = DAC_CYC[DAC_W-1:0];

    logic [IDX_W-1:0] idx;
    step_t            step;
    logic             delay_load;
    logic             delay_is_lock;
    logic             delay_done;
    logic             dac_load;
    logic             dac_ok;
    logic [DLY_W-1:0] delay_val;

    lo_seq_rom u_rom (
        .idx_i  (idx),
        .step_o (step)
    );

    lo_seq_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .stop_i          (stop_i),
        .step_i          (step),
        .delay_done_i    (delay_done),
        .dac_ok_i        (dac_ok),
        .wr_ready_i      (wr_ready_i),
        .idx_o           (idx),
        .wr_valid_o      (wr_valid_o),
        .wr_addr_o       (wr_addr_o),
        .wr_data_o       (wr_data_o),
        .delay_load_o    (delay_load),
        .delay_is_lock_o (delay_is_lock),
        .dac_load_o      (dac_load),
        .busy_o          (busy_o),
        .playing_o       (playing_o),
        .done_o          (done_o),
        .cmd_err_o       (cmd_err_o)
    );

    // Shared delay: PLL lock after the rate write, settle after power writes
    assign delay_val = delay_is_lock ? LOCK_LD : SETTLE_LD;

    lo_delay_timer #(.CW(DLY_W)) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (delay_load),
        .load_val_i (delay_val),
        .expired_o  (delay_done)
    );

    // DAC-invalid window: omitted when it rounds to zero cycles
    generate
        if (DAC_CYC == 0) begin : g_no_dac_win
            assign dac_ok = 1'b1;
        end else begin : g_dac_win
            lo_delay_timer #(.CW(DAC_W)) u_dac_win (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_i     (dac_load),
                .load_val_i (DAC_LD),
                .expired_o  (dac_ok)
            );
        end
    endgenerate

endmodule

// File: tb/lineout_pwr_seq_tb.sv
module lineout_pwr_seq_tb_top;

    localparam longint unsigned T_CLK  = 64'd50_000_000;
    localparam longint unsigned T_DIV  = 64'd50_000;
    localparam longint unsigned T_SMS  = 64'd300;
    localparam longint unsigned T_LUS  = 64'd40_000;
    localparam int SET = int'((T_CLK * T_SMS + 64'd1000 * T_DIV - 1) / (64'd1000 * T_DIV));
    localparam int LCK = int'((T_CLK * T_LUS + 64'd1_000_000 * T_DIV - 1) / (64'd1_000_000 * T_DIV));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic stop_i = 1'b0;
    logic wr_ready_i = 1'b0;
    logic wr_valid_o, busy_o, playing_o, done_o, cmd_err_o;
    logic [7:0] wr_addr_o, wr_data_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int n = 0;
    int rise_cyc [0:63];
    int acc_cyc  [0:63];
    logic [7:0] log_a [0:63];
    logic [7:0] log_d [0:63];
    int force_idx = -1;
    int force_val = 0;
    int lat = 0;
    int wcnt = 0;
    logic prev_v = 1'b0;
    logic [7:0] prev_a = 8'h00, prev_d = 8'h00;
    bit finished = 1'b0;
    int unsigned seed_val;

    lineout_pwr_seq #(
        .CLK_HZ(T_CLK), .SETTLE_MS(T_SMS), .LOCK_US(T_LUS),
        .FS_HZ(64'd44_100), .DAC_SAMPLES(64'd67), .TEST_DIV(T_DIV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .playing_o(playing_o), .done_o(done_o), .cmd_err_o(cmd_err_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected write list: index 0..6 power-up, 7..10 power-down
    function automatic logic [15:0] exp_wr(input int i);
        case (i)
            0: return 16'h0527;  1: return 16'h0210;  2: return 16'h0A91;
            3: return 16'h0D91;  4: return 16'h0340;  5: return 16'h006C;
            6: return 16'h0300;  7: return 16'h0340;  8: return 16'h0040;
            9: return 16'h0200;  default: return 16'h0300;
        endcase
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // Bus writer model and write monitor, acting on falling edges
    always @(negedge clk) begin
        if (!rst_n) begin
            wr_ready_i = 1'b0;
            prev_v = 1'b0;
        end else begin
            if (wr_valid_o && !prev_v) begin
                rise_cyc[n] = cyc;
                wcnt = 0;
                lat = (n == force_idx) ? force_val : int'($urandom_range(0, 3));
            end
            if (wr_valid_o && prev_v && !wr_ready_i) begin
                chk(wr_addr_o == prev_a && wr_data_o == prev_d, "R3", "held write changed",
                    {wr_addr_o, wr_data_o}, {prev_a, prev_d});
            end
            if (!wr_valid_o) begin
                wr_ready_i = 1'b0;
            end else if (!wr_ready_i) begin
                if (wcnt >= lat) wr_ready_i = 1'b1;
                else wcnt++;
                if (wr_ready_i && n < 64) begin
                    log_a[n] = wr_addr_o;
                    log_d[n] = wr_data_o;
                    acc_cyc[n] = cyc + 1;
                    n++;
                end
            end
            prev_v = wr_valid_o;
            prev_a = wr_addr_o;
            prev_d = wr_data_o;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check_writes(input int base, input int first, input int cnt, input string req);
        for (int i = 0; i < cnt; i++) begin
            chk({log_a[base+i], log_d[base+i]} == exp_wr(first + i), req, "write order",
                {log_a[base+i], log_d[base+i]}, exp_wr(first + i));
        end
    endtask

    task automatic run_up(input bit inject);
        int base;
        bit injd;
        base = n;
        injd = 1'b0;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        while (n < base + 7) begin
            if (inject && !injd && n == base + 2) begin
                stop_i = 1'b1;
                start_i = 1'b1;
                injd = 1'b1;
            end else begin
                stop_i = 1'b0;
                start_i = 1'b0;
            end
            step();
        end
        start_i = 1'b0;
        stop_i = 1'b0;
        chk(playing_o == 1'b0, "R8", "playing before last accept", playing_o, 0);
        step();
        chk(playing_o == 1'b1, "R8", "playing after last accept", playing_o, 1);
        chk(done_o == 1'b1, "R10", "done after power-up", done_o, 1);
        chk(busy_o == 1'b0, "R9", "busy in playback", busy_o, 0);
        step();
        chk(done_o == 1'b0, "R10", "done one cycle", done_o, 0);
        check_writes(base, 0, 7, "R2");
        for (int i = 1; i < 5; i++)
            chk(rise_cyc[base+i] == acc_cyc[base+i-1] + 1, "R3", "ungated offer edge",
                rise_cyc[base+i], acc_cyc[base+i-1] + 1);
        chk(rise_cyc[base+5] == imax(acc_cyc[base+4] + 1, acc_cyc[base] + LCK + 1), "R5",
            "power write after lock", rise_cyc[base+5],
            imax(acc_cyc[base+4] + 1, acc_cyc[base] + LCK + 1));
        chk(rise_cyc[base+6] == acc_cyc[base+5] + SET + 1, "R4", "settle before playback",
            rise_cyc[base+6], acc_cyc[base+5] + SET + 1);
        if (inject)
            chk(cmd_err_o == 1'b1, "R11", "error after busy command", cmd_err_o, 1);
    endtask

    task automatic run_down(input int lat9);
        int base;
        int exp_r;
        base = n;
        force_idx = (lat9 >= 0) ? base + 2 : -1;
        force_val = lat9;
        stop_i = 1'b1;
        step();
        stop_i = 1'b0;
        chk(playing_o == 1'b0, "R8", "playing after stop", playing_o, 0);
        chk(busy_o == 1'b1, "R9", "busy after stop", busy_o, 1);
        while (n < base + 4) step();
        step();
        chk(done_o == 1'b1, "R10", "done after power-down", done_o, 1);
        chk(busy_o == 1'b0, "R9", "busy in idle", busy_o, 0);
        step();
        chk(done_o == 1'b0, "R10", "done one cycle down", done_o, 0);
        force_idx = -1;
        check_writes(base, 7, 4, "R6");
        chk(rise_cyc[base+2] == acc_cyc[base+1] + 1, "R7", "route removal not held",
            rise_cyc[base+2], acc_cyc[base+1] + 1);
        exp_r = imax(acc_cyc[base+2] + 1, acc_cyc[base+1] + SET + 1);
        chk(rise_cyc[base+3] == exp_r, "R7", "fall wait before final", rise_cyc[base+3], exp_r);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int nsave;
        seed_val = $urandom(32'd4242);
        repeat (3) step();
        chk({wr_valid_o, busy_o, playing_o, done_o, cmd_err_o} == 5'b0, "R1", "reset outputs",
            {wr_valid_o, busy_o, playing_o, done_o, cmd_err_o}, 0);
        rst_n = 1'b1;
        repeat (3) step();
        // R11: stop in idle is refused
        stop_i = 1'b1;
        step();
        stop_i = 1'b0;
        repeat (3) step();
        chk(cmd_err_o == 1'b1, "R11", "stop in idle flags", cmd_err_o, 1);
        chk(n == 0 && busy_o == 1'b0, "R11", "stop in idle ignored", n, 0);
        // R1: reset clears the sticky flag
        rst_n = 1'b0;
        step();
        step();
        chk(cmd_err_o == 1'b0 && wr_valid_o == 1'b0, "R1", "reset clears error", cmd_err_o, 0);
        rst_n = 1'b1;
        step();
        for (int it = 0; it < 5; it++) begin
            run_up(it == 0);
            // R11: start in playback is refused
            nsave = n;
            start_i = 1'b1;
            step();
            start_i = 1'b0;
            repeat (4) step();
            chk(cmd_err_o == 1'b1, "R11", "error sticky", cmd_err_o, 1);
            chk(playing_o == 1'b1 && busy_o == 1'b0, "R11", "start in playback ignored",
                playing_o, 1);
            chk(n == nsave, "R11", "no write from refused start", n, nsave);
            repeat (int'($urandom_range(1, 6))) step();
            case (it)
                0: run_down(-1);
                1: run_down(SET - 3);
                2: run_down(SET - 2);
                3: run_down(SET - 1);
                default: run_down(0);
            endcase
            nsave = n;
            repeat (5) step();
            chk(n == nsave && wr_valid_o == 1'b0, "R3", "no extra write in idle", n, nsave);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule